// File: doc/BRIEF.md
# Synchronous Byte Shifter with Selectable Clock Polarity and Phase

This block runs a serial port as a synchronous master. A byte handed in on the transmit side is shifted out on a data line, one bit for each cycle of a serial clock that the block generates. At the same time a byte is shifted in from a receive data line. Each clock cycle of the serial clock spans two ticks of an external divider strobe. Framing bits (start, stop and parity) are not used. Only the data bits are moved, most significant bit first.

Two mode inputs select one of four combinations of clock polarity and clock phase. The invert input sets the idle level of the serial clock. The phase input selects which of the two edges in a bit period samples the receive line and which edge puts the next transmit bit on the line. The leading edge of a bit period is the one that leaves the idle level. The trailing edge is the one that returns to it. The mode inputs are captured when a transfer is accepted.

The transmit side is a valid/ready input. A byte is taken only in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low for the whole transfer, so the source must hold its byte until it is accepted. A valid presented while ready is low has no effect. The receive side has no back-pressure: `rx_valid` is a one-cycle pulse, and `rx_byte` must be taken in that cycle.

Top module: `sync_shift_master`

## Requirements
- R1: While no transfer runs, `sclk` equals `cfg_invert` of the previous cycle, so it idles low when invert is off and high when it is on. During a transfer, `sclk` changes only in the cycle after a `div_tick`.
- R2: A transfer is accepted when `tx_valid` and `tx_ready` are both high. `tx_ready` is low from the next cycle until the transfer ends. A `tx_valid` raised while `tx_ready` is low starts nothing.
- R3: A transfer lasts exactly 16 `div_tick`s and produces 16 `sclk` edges, which is 8 full clock cycles. `sclk` then rests at the idle level that was captured at acceptance.
- R4: With phase = 0 (modes 0 and 2), the first transmit bit is on `sdo` before the first leading edge. `sdi` is sampled on each leading edge, and `sdo` is updated on each trailing edge.
- R5: With phase = 1 (modes 1 and 3), `sdo` is updated on each leading edge, and `sdi` is sampled on each trailing edge.
- R6: Exactly 8 data bits are sent and received, most significant bit first, with no start, stop or parity bits.
- R7: `rx_valid` is high for exactly one cycle, the cycle after the 16th edge. In that cycle `rx_byte` holds the 8 bits sampled from `sdi`, the first sampled bit in bit 7.
- R8: `cfg_invert` and `cfg_phase` are captured at acceptance. Changing them during a transfer has no effect on that transfer.
- R9: After reset, `sclk` and `sdo` are low, `tx_ready` is high and `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_tick | input | 1 | Divider strobe; one serial clock edge for each tick during a transfer |
| cfg_invert | input | 1 | Clock polarity: 0 idles low, 1 idles high |
| cfg_phase | input | 1 | Clock phase: 0 samples on the leading edge, 1 samples on the trailing edge |
| tx_valid | input | 1 | Transmit byte is offered |
| tx_ready | output | 1 | Block can accept a byte |
| tx_byte | input | 8 | Byte to send |
| sclk | output | 1 | Generated serial clock |
| sdo | output | 1 | Serial transmit data |
| sdi | input | 1 | Serial receive data |
| rx_valid | output | 1 | One-cycle pulse marking a completed byte |
| rx_byte | output | 8 | Received byte |

## Verification
The bench runs a slave model that follows the edge rules of R4 and R5 in all four modes. Each transfer is checked in both directions. A design that drove the first bit late in the phase-0 modes would lose bit 7. A design that swapped the sample and update edges would return bytes shifted by one bit.

Further cases target the edges of a transfer:
- The mode inputs are flipped just after acceptance. A design that did not capture them would change polarity partway through the transfer.
- A second byte is offered while a transfer runs. A design that leaked it would start an extra transfer.
- The divider spacing varies from one tick every cycle to one every four cycles. A design that counted system cycles instead of ticks would give the wrong edge count.
- All-zero and all-one bytes are sent. A design with a stuck data line would fail on one of them.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef struct packed {
    logic inv;
    logic pha;
  } ssm_mode_t;
endpackage

// File: rtl/ssm_seq.sv
module ssm_seq
  import ssm_pkg::*;
#(
  parameter int EDGES = 16,
  localparam int CNT_W = $clog2(EDGES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  ssm_mode_t cfg,
  output logic busy,
  output logic sclk,
  output logic setup_stb,
  output logic sample_stb,
  output logic done
);
  ssm_mode_t         mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              edge_now, lead, last, sample_kind;

  assign edge_now    = busy && tick;
  assign lead        = ~cnt_q[0];
  assign last        = edge_now && (cnt_q == CNT_W'(EDGES - 1));
  assign sample_kind = lead ^ mode_q.pha;
  assign sample_stb  = edge_now && sample_kind;
  assign setup_stb   = edge_now && !sample_kind && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sclk   <= 1'b0;
      cnt_q  <= '0;
      mode_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cfg.inv;
        if (start) begin
          busy   <= 1'b1;
          cnt_q  <= '0;
          mode_q <= cfg;
        end
      end else if (tick) begin
        sclk  <= ~sclk;
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  p_sclk_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sclk));
  p_idle_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sclk == mode_q.inv));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));
endmodule

// File: rtl/ssm_tx.sv
module ssm_tx #(
  parameter int W = 8,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         pha,
  input  logic [W-1:0] data,
  input  logic         setup,
  output logic         sdo
);
  logic [W-1:0] sh_q, data_nxt, sh_nxt;
  logic         data_head, sh_head;

  generate
    if (MSB_FIRST) begin : g_msb
      assign data_head = data[W-1];
      assign sh_head   = sh_q[W-1];
      assign data_nxt  = {data[W-2:0], 1'b0};
      assign sh_nxt    = {sh_q[W-2:0], 1'b0};
    end else begin : g_lsb
      assign data_head = data[0];
      assign sh_head   = sh_q[0];
      assign data_nxt  = {1'b0, data[W-1:1]};
      assign sh_nxt    = {1'b0, sh_q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      sdo  <= 1'b0;
    end else if (load) begin
      if (!pha) begin
        sdo  <= data_head;
        sh_q <= data_nxt;
      end else begin
        sh_q <= data;
      end
    end else if (setup) begin
      sdo  <= sh_head;
      sh_q <= sh_nxt;
    end
  end
endmodule

// File: rtl/ssm_rx.sv
module ssm_rx #(
  parameter int W = 8,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         sdi,
  output logic [W-1:0] data
);
  logic [W-1:0] nxt;

  generate
    if (MSB_FIRST) begin : g_msb
      assign nxt = {data[W-2:0], sdi};
    end else begin : g_lsb
      assign nxt = {sdi, data[W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data <= '0;
    else if (sample) data <= nxt;
  end
endmodule

// File: rtl/sync_shift_master.sv
module sync_shift_master
  import ssm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit MSB_FIRST = 1'b1,
  localparam int EDGES = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_tick,
  input  logic              cfg_invert,
  input  logic              cfg_phase,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte
);
  ssm_mode_t cfg;
  logic busy, start, setup_stb, sample_stb;

  assign cfg.inv  = cfg_invert;
  assign cfg.pha  = cfg_phase;
  assign tx_ready = !busy;
  assign start    = tx_valid && tx_ready;

  ssm_seq #(.EDGES(EDGES)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(div_tick), .start(start), .cfg(cfg),
    .busy(busy), .sclk(sclk), .setup_stb(setup_stb), .sample_stb(sample_stb),
    .done(rx_valid)
  );

  ssm_tx #(.W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(start), .pha(cfg_phase), .data(tx_byte),
    .setup(setup_stb), .sdo(sdo)
  );

  ssm_rx #(.W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(sample_stb), .sdi(sdi), .data(rx_byte)
  );

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> tx_ready);
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(setup_stb && sample_stb));
endmodule

// File: tb/tb_sync_shift_master.sv
module tb_sync_shift_master;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, div_tick = 1'b0;
  logic cfg_invert = 1'b0, cfg_phase = 1'b0, tx_valid = 1'b0, sdi = 1'b0;
  logic [7:0] tx_byte = '0;
  logic tx_ready, sclk, sdo, rx_valid;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0, cycles = 0;
  int tick_div = 1, tick_cnt = 0;

  bit slv_on = 1'b0, slv_inv = 1'b0, slv_pha = 1'b0, prev_sclk = 1'b0;
  logic [7:0] slv_tx = '0, slv_rx = '0;
  int n_lead = 0;

  sync_shift_master dut (
    .clk(clk), .rst_n(rst_n), .div_tick(div_tick), .cfg_invert(cfg_invert),
    .cfg_phase(cfg_phase), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_byte(tx_byte), .sclk(sclk), .sdo(sdo), .sdi(sdi),
    .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % tick_div;
    div_tick = (tick_cnt == 0);
  end

  // slave model: leading edge leaves idle level
  always @(negedge clk) begin
    if (slv_on && sclk != prev_sclk) begin
      bit lead;
      lead = (sclk != slv_inv);
      if (lead) n_lead++;
      if (lead ^ slv_pha) slv_rx = {slv_rx[6:0], sdo};
      else begin
        sdi = slv_tx[7];
        slv_tx = {slv_tx[6:0], 1'b0};
      end
    end
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit inv, input bit pha, input logic [7:0] m,
                      input logic [7:0] s, input int div, input bit flip,
                      input bit poke);
    int waitc;
    tick_div = div;
    @(negedge clk);
    cfg_invert = inv; cfg_phase = pha;
    @(negedge clk);
    #1;
    chk(sclk == inv, "R1 idle level", sclk, inv);
    slv_inv = inv; slv_pha = pha; slv_rx = '0; n_lead = 0;
    slv_tx = s;
    if (!pha) begin sdi = s[7]; slv_tx = {s[6:0], 1'b0}; end
    prev_sclk = sclk;
    slv_on = 1'b1;
    tx_valid = 1'b1; tx_byte = m;
    @(negedge clk);
    tx_valid = 1'b0;
    if (flip) begin cfg_invert = ~inv; cfg_phase = ~pha; end
    #1;
    chk(tx_ready == 1'b0, "R2 ready low while busy", tx_ready, 0);
    if (poke) begin
      tx_valid = 1'b1; tx_byte = ~m;
      @(negedge clk);
      tx_valid = 1'b0;
    end
    waitc = 0;
    while (!rx_valid && waitc < 200) begin
      @(negedge clk); waitc++;
    end
    #1;
    chk(rx_valid == 1'b1, "R7 done pulse seen", rx_valid, 1);
    chk(rx_byte == s, "R7 R4 R5 R6 received byte", rx_byte, s);
    chk(slv_rx == m, "R4 R5 R6 R8 sent byte", slv_rx, m);
    chk(n_lead == 8, "R3 clock cycles", n_lead, 8);
    chk(sclk == inv, "R3 R8 clock back at latched idle", sclk, inv);
    slv_on = 1'b0;
    @(negedge clk); #1;
    chk(rx_valid == 1'b0, "R7 pulse width", rx_valid, 0);
    chk(sclk == cfg_invert, "R1 idle follows invert", sclk, cfg_invert);
    if (poke) begin
      waitc = 0;
      repeat (40) begin
        @(negedge clk);
        if (rx_valid || !tx_ready) waitc++;
      end
      chk(waitc == 0, "R2 valid while busy ignored", waitc, 0);
    end
    cfg_invert = inv; cfg_phase = pha;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk(sclk == 1'b0, "R9 reset sclk", sclk, 0);
    chk(sdo == 1'b0, "R9 reset sdo", sdo, 0);
    chk(tx_ready == 1'b1, "R9 reset ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R9 reset valid", rx_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int md = 0; md < 4; md++) begin
      xfer(md[1], md[0], 8'hA5, 8'h3C, 1, 1'b0, 1'b0);
      xfer(md[1], md[0], 8'h00, 8'hFF, 2, 1'b1, 1'b0);
      xfer(md[1], md[0], 8'hFF, 8'h00, 3, 1'b1, 1'b1);
      xfer(md[1], md[0], 8'h81, 8'h7E, 4, 1'b0, 1'b0);
    end
    for (int i = 0; i < 32; i++) begin
      bit ri, rp, rf, rk;
      ri = 1'($urandom); rp = 1'($urandom);
      rf = 1'($urandom); rk = ($urandom % 4) == 0;
      xfer(ri, rp, 8'($urandom), 8'($urandom), 1 + int'($urandom % 4), rf, rk);
    end
    summary();
  end
endmodule